// File: doc/BRIEF.md
# Register Data-Processing ALU

This block is the execute-stage arithmetic and logic unit of a 32-bit load/store processor. Each cycle in which `valid_i` is high it takes an operation code, a first operand, a second operand that an upstream shifter has already prepared, and that shifter's carry-out. It also takes the set-flags bit and the architectural NZCV flags as they stand before the operation. One clock edge later it presents the result, the destination write-enable and the next value of the NZCV flags.

The sixteen operations split into four groups: add and subtract forms with and without carry (including reverse subtract), bitwise operations (including bit-clear), flag-only comparisons and tests, and moves that ignore the first operand. Comparisons and tests always update the flags and never write a register. Every other operation updates the flags only when the set-flags bit is high. The operands always come from registers. Memory access, operand shifting and condition gating are done elsewhere.

Top module: `dp_alu`

## Requirements
- R1: Outputs are registered one cycle after the input cycle. `rd_we_o` is 1 after a valid non-compare operation. It is 0 after an idle cycle (`valid_i` low), and `res_o` then holds its previous value.
- R2: Opcode values are 4 ADD (rn+op2), 5 ADC (rn+op2+C), 2 SUB (rn-op2), 6 SBC (rn-op2-!C) and 3 RSB (op2-rn), 7 RSC (op2-rn-!C). C is `flags_i[1]`. Results wrap modulo 2^32.
- R3: For every add form, C is the carry out of bit 31. For every subtract form, C is NOT borrow, so it is 1 when no borrow occurs.
- R4: Bitwise opcodes are 0 AND, 1 EOR, 12 ORR and 14 BIC (rn AND NOT op2).
- R5: Opcode 13 MOV gives op2 and opcode 15 MVN gives NOT op2. The value of `rn_i` has no effect on either.
- R6: Opcodes 8 TST (AND), 9 TEQ (EOR), 10 CMP (subtract) and 11 CMN (add) never assert `rd_we_o`. They update the flags even when `set_flags_i` is 0.
- R7: When the cycle is idle, or a non-compare operation has `set_flags_i`=0, `flags_o` equals the `flags_i` of that input cycle.
- R8: When flags update, N (bit 3) is bit 31 of the result and Z (bit 2) is 1 exactly when the result is zero. Flag order is {N,Z,C,V}.
- R9: For bitwise, move and test operations that update flags, C (bit 1) takes `sh_carry_i` and V (bit 0) keeps `flags_i[0]`.
- R10: For add and subtract forms that update flags, V is 1 exactly when the signed two's-complement result overflows 32 bits.
- R11: While `rst_ni` is low, `res_o`, `rd_we_o` and `flags_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Update flags for non-compare operations |
| rn_i | input | 32 | First operand |
| op2_i | input | 32 | Shifted second operand |
| sh_carry_i | input | 1 | Carry-out of the shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| res_o | output | 32 | Result |
| rd_we_o | output | 1 | Destination write-enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
Two functions can land in the same cycle. In one case the destination write and the flag-hold path coincide: an add that carries or overflows while the set-flags bit is low must write its result and leave all four flags as they came in. In the other case the flag update and the write suppression coincide: a compare or test with the set-flags bit low must change the flags and assert no write. The bench provokes both with directed operands at the carry and overflow edges, then with random opcodes, operands, flag inputs and set-flags bits. A behavioural integer model judges the result, the write-enable and the flags on every clock.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dp_op_e;

  typedef enum logic [1:0] {
    LU_AND = 2'd0,
    LU_EOR = 2'd1,
    LU_ORR = 2'd2,
    LU_BIC = 2'd3
  } lu_sel_e;

  typedef enum logic [1:0] {
    CI_ZERO  = 2'd0,
    CI_ONE   = 2'd1,
    CI_CARRY = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic     arith;     // adder path, else logic unit
    logic     swap;      // reverse operand order
    logic     inv_b;     // subtract: invert second adder input
    cin_sel_e cin_sel;
    logic     no_write;  // compare/test
    lu_sel_e  lu_sel;
    logic     use_rn;    // moves replace rn by all ones
  } dp_dec_t;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output dp_dec_t    dec_o
);

  always_comb begin
    dec_o = '{arith: 1'b0, swap: 1'b0, inv_b: 1'b0, cin_sel: CI_ZERO,
              no_write: 1'b0, lu_sel: LU_AND, use_rn: 1'b1};
    unique case (dp_op_e'(op_i))
      OP_AND: dec_o.lu_sel = LU_AND;
      OP_EOR: dec_o.lu_sel = LU_EOR;
      OP_ORR: dec_o.lu_sel = LU_ORR;
      OP_BIC: dec_o.lu_sel = LU_BIC;
      OP_TST: begin dec_o.lu_sel = LU_AND; dec_o.no_write = 1'b1; end
      OP_TEQ: begin dec_o.lu_sel = LU_EOR; dec_o.no_write = 1'b1; end
      OP_MOV: begin dec_o.lu_sel = LU_AND; dec_o.use_rn = 1'b0; end
      OP_MVN: begin dec_o.lu_sel = LU_BIC; dec_o.use_rn = 1'b0; end
      OP_ADD: begin dec_o.arith = 1'b1; end
      OP_ADC: begin dec_o.arith = 1'b1; dec_o.cin_sel = CI_CARRY; end
      OP_CMN: begin dec_o.arith = 1'b1; dec_o.no_write = 1'b1; end
      OP_SUB: begin
        dec_o.arith = 1'b1; dec_o.inv_b = 1'b1; dec_o.cin_sel = CI_ONE;
      end
      OP_CMP: begin
        dec_o.arith = 1'b1; dec_o.inv_b = 1'b1; dec_o.cin_sel = CI_ONE;
        dec_o.no_write = 1'b1;
      end
      OP_SBC: begin
        dec_o.arith = 1'b1; dec_o.inv_b = 1'b1; dec_o.cin_sel = CI_CARRY;
      end
      OP_RSB: begin
        dec_o.arith = 1'b1; dec_o.inv_b = 1'b1; dec_o.cin_sel = CI_ONE;
        dec_o.swap = 1'b1;
      end
      OP_RSC: begin
        dec_o.arith = 1'b1; dec_o.inv_b = 1'b1; dec_o.cin_sel = CI_CARRY;
        dec_o.swap = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  localparam int unsigned MSB = W - 1;

  logic [W:0] wide;

  always_comb begin
    wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = wide[MSB:0];
    cout_o = wide[W];
    // same-sign inputs, different-sign output
    ovf_o  = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/dp_logic.sv
module dp_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lu_sel_e      sel_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    unique case (sel_i)
      LU_AND:  y_o = a_i & b_i;
      LU_EOR:  y_o = a_i ^ b_i;
      LU_ORR:  y_o = a_i | b_i;
      LU_BIC:  y_o = a_i & ~b_i;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic         set_flags_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  input  logic         sh_carry_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic         rd_we_o,
  output logic [3:0]   flags_o
);

  localparam int unsigned MSB = W - 1;

  dp_dec_t dec;

  dp_decode u_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  // adder path
  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_cout, add_ovf;

  always_comb begin
    add_a = dec.swap ? op2_i : rn_i;
    add_b = dec.swap ? rn_i  : op2_i;
    if (dec.inv_b) add_b = ~add_b;
    unique case (dec.cin_sel)
      CI_ONE:   add_cin = 1'b1;
      CI_CARRY: add_cin = flags_i[FLAG_C];
      default:  add_cin = 1'b0;
    endcase
  end

  dp_addsub #(.W(W)) u_add (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  // logic path; moves see all ones in place of rn
  logic [W-1:0] lu_a, lu_y;

  assign lu_a = dec.use_rn ? rn_i : {W{1'b1}};

  dp_logic #(.W(W)) u_lu (
    .a_i   (lu_a),
    .b_i   (op2_i),
    .sel_i (dec.lu_sel),
    .y_o   (lu_y)
  );

  logic [W-1:0] res_d;
  logic [3:0]   flags_new, flags_d;
  logic         upd;

  always_comb begin
    res_d             = dec.arith ? add_sum : lu_y;
    upd               = valid_i && (dec.no_write || set_flags_i);
    flags_new[FLAG_N] = res_d[MSB];
    flags_new[FLAG_Z] = (res_d == '0);
    flags_new[FLAG_C] = dec.arith ? add_cout : sh_carry_i;
    flags_new[FLAG_V] = dec.arith ? add_ovf  : flags_i[FLAG_V];
    flags_d           = upd ? flags_new : flags_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      rd_we_o <= 1'b0;
      flags_o <= '0;
    end else begin
      if (valid_i) res_o <= res_d;
      rd_we_o <= valid_i && !dec.no_write;
      flags_o <= flags_d;
    end
  end

  // R6: compares and tests never write
  p_cmp_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[3:2] == 2'b10) |=> !rd_we_o);

  // R1: idle cycle gives no write, result held
  p_idle_no_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!rd_we_o && $stable(res_o)));

  // R7: no update, flags pass through
  p_hold_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || (!set_flags_i && op_i[3:2] != 2'b10)) |=> flags_o == $past(flags_i));

  // R9: logical updates take shifter carry, keep V
  p_logic_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !dec.arith) |=> (flags_o[FLAG_C] == $past(sh_carry_i)
                             && flags_o[FLAG_V] == $past(flags_i[FLAG_V])));

  // R8: Z tracks the written result
  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !dec.no_write) |=> (flags_o[FLAG_Z] == (res_o == '0)
                                && flags_o[FLAG_N] == res_o[MSB]));

  // R5: moves never see rn
  p_mov_ignores_rn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd13) |=> res_o == $past(op2_i));

endmodule

// File: tb/sim_dp_alu.sv
`timescale 1ns/1ps
module sim_dp_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic        sf = 1'b0;
  logic [31:0] rn = '0, op2 = '0;
  logic        shc = 1'b0;
  logic [3:0]  fl = '0;
  logic [31:0] res;
  logic        we;
  logic [3:0]  fo;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] e_res = '0;
  logic        e_we = 1'b0;
  logic [3:0]  e_fl = '0;
  string       t_res = "R1", t_we = "R1", t_fl = "R7";

  always #2.5 clk = ~clk;

  dp_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .set_flags_i(sf), .rn_i(rn), .op2_i(op2), .sh_carry_i(shc),
    .flags_i(fl), .res_o(res), .rd_we_o(we), .flags_o(fo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (op=%0d)", tag, act, exp, op);
    end
  endtask

  function automatic bit ovf(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  // behavioural reference for the inputs currently applied
  task automatic model();
    longint ua, ub, sa, sb, u, s;
    bit c_in, c, v, cmp, arith, sub;
    logic [31:0] r;
    c_in = fl[1];
    ua = longint'({32'b0, rn});  ub = longint'({32'b0, op2});
    sa = longint'($signed(rn));  sb = longint'($signed(op2));
    arith = 1; sub = 0; c = 0; v = 0;
    cmp = (op >= 4'd8 && op <= 4'd11);
    case (op)
      4'd4, 4'd11: begin u = ua + ub; s = sa + sb; end
      4'd5: begin u = ua + ub + c_in; s = sa + sb + c_in; end
      4'd2, 4'd10: begin sub = 1; u = ua - ub; s = sa - sb; c = (ua >= ub); end
      4'd6: begin sub = 1; u = ua - ub - (1 - c_in); s = sa - sb - (1 - c_in);
                  c = (ua >= ub + (1 - c_in)); end
      4'd3: begin sub = 1; u = ub - ua; s = sb - sa; c = (ub >= ua); end
      4'd7: begin sub = 1; u = ub - ua - (1 - c_in); s = sb - sa - (1 - c_in);
                  c = (ub >= ua + (1 - c_in)); end
      default: begin arith = 0; u = 0; s = 0; end
    endcase
    if (arith) begin
      r = u[31:0];
      if (!sub) c = u[32];
      v = ovf(s);
    end else begin
      case (op)
        4'd0, 4'd8: r = rn & op2;
        4'd1, 4'd9: r = rn ^ op2;
        4'd12:      r = rn | op2;
        4'd14:      r = rn & ~op2;
        4'd13:      r = op2;
        default:    r = ~op2;
      endcase
      c = shc; v = fl[0];
    end
    if (valid) begin
      e_res = r;
      t_res = arith ? "R2" : ((op == 4'd13 || op == 4'd15) ? "R5" : "R4");
      e_we  = !cmp;
      t_we  = cmp ? "R6" : "R1";
    end else begin
      e_we = 0; t_we = "R1"; t_res = "R1";
    end
    if (valid && (cmp || sf)) begin
      e_fl = {r[31], r == 32'd0, c, v};
      t_fl = cmp ? "R6/R8" : (arith ? "R3/R8/R10" : "R8/R9");
    end else begin
      e_fl = fl; t_fl = "R7";
    end
  endtask

  task automatic step(input bit vv, input logic [3:0] o, input bit s,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit sh, input logic [3:0] f);
    @(negedge clk);
    chk(t_res, res, e_res);
    chk(t_we, {31'b0, we}, {31'b0, e_we});
    chk(t_fl, {28'b0, fo}, {28'b0, e_fl});
    valid = vv; op = o; sf = s; rn = a; op2 = b; shc = sh; fl = f;
    model();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", res, 32'd0);
    chk("R11", {31'b0, we}, 32'd0);
    chk("R11", {28'b0, fo}, 32'd0);
    rst_n = 1'b1;
    // add carry/overflow edges
    step(1, 4'd4, 1, 32'hFFFF_FFFF, 32'd1, 0, 4'b0000);
    step(1, 4'd4, 1, 32'h7FFF_FFFF, 32'd1, 0, 4'b0000);
    step(1, 4'd5, 1, 32'd5, 32'd6, 0, 4'b0010);
    // subtract forms, NOT-borrow
    step(1, 4'd2, 1, 32'd9, 32'd9, 0, 4'b0000);
    step(1, 4'd2, 1, 32'd0, 32'd1, 0, 4'b0000);
    step(1, 4'd2, 1, 32'h8000_0000, 32'd1, 0, 4'b0000);
    step(1, 4'd6, 1, 32'd10, 32'd3, 0, 4'b0000);
    step(1, 4'd6, 1, 32'd3, 32'd3, 0, 4'b0000);
    step(1, 4'd3, 1, 32'd4, 32'd10, 0, 4'b0000);
    step(1, 4'd7, 1, 32'd4, 32'd4, 0, 4'b0010);
    // write with flags held (same-cycle pair)
    step(1, 4'd4, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 4'b0101);
    // logicals and moves
    step(1, 4'd0, 1, 32'hF0F0_0000, 32'h0F0F_FFFF, 1, 4'b0001);
    step(1, 4'd14, 1, 32'hFFFF_FFFF, 32'hFFFF_0000, 0, 4'b1111);
    step(1, 4'd13, 1, 32'hDEAD_BEEF, 32'h8000_0000, 1, 4'b0000);
    step(1, 4'd15, 1, 32'h1234_5678, 32'hFFFF_FFFF, 0, 4'b0001);
    // compares with set-flags low (same-cycle pair)
    step(1, 4'd10, 0, 32'd7, 32'd7, 0, 4'b0000);
    step(1, 4'd11, 0, 32'hFFFF_FFFF, 32'd1, 0, 4'b1000);
    step(1, 4'd8, 0, 32'hFF00, 32'h00FF, 1, 4'b0001);
    step(1, 4'd9, 0, 32'h55, 32'h55, 0, 4'b1010);
    // idle: result held, no write
    step(0, 4'd4, 1, 32'd1, 32'd1, 0, 4'b0110);
    step(0, 4'd10, 1, 32'd1, 32'd2, 1, 4'b1001);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (($urandom % 8) == 0) a = {32{a[0]}} ^ {1'b1, 31'b0};
      if (($urandom % 8) == 0) b = a;
      step(($urandom % 6) != 0, 4'($urandom), 1'($urandom), a, b,
           1'($urandom), 4'($urandom));
    end
    step(0, 4'd0, 0, 32'd0, 32'd0, 0, 4'b0000);
    step(0, 4'd0, 0, 32'd0, 32'd0, 0, 4'b0000);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule